// File: doc/BRIEF.md
# Key-Gated Configuration Controller Register Bank

This block is the software-visible register bank of a configuration controller. A host reaches it over a plain single-cycle bus made of valid, write, byte address and 32-bit data signals. The bank holds these registers:

- a control word that drives the program, port-enable and partial-reconfiguration controls;
- a small lock word;
- four DMA address and length words;
- a miscellaneous control word with a loopback select;
- a read-only status word;
- an interrupt status and interrupt mask pair.

The neighbouring DMA and configuration logic reports events as one-cycle pulses on `evt_set` and reports levels on `dma_queue_full` and `init_level`.

After reset the bank is locked. Software must first write a fixed 32-bit key to the unlock register, and only then do writes to the other registers take effect. Interrupt status bits are sticky and are cleared by writing a one to them. A separate mask register selects which status bits may raise the single registered interrupt line.

Top module: `cfgctl_regbank`

## Requirements
- R1: After reset:
  - the bank is locked and `irq_out` is low;
  - the mask register (offset 0x10) reads 0xF8F7F87F;
  - every other storage register reads zero, and so do `ctrl_out`, `lock_out`, `misc_out` and the four DMA outputs.
- R2: Unlock register (offset 0x34):
  - a write of 0x757BDF0D unlocks the bank, and it stays unlocked until reset whatever is written to this register later;
  - a write of any other value leaves a locked bank locked;
  - the register always reads zero.
- R3: While the bank is locked, writes to every offset other than 0x34 have no effect. This covers storage registers and the clearing of interrupt status.
- R4: Only some bits are implemented in three registers, and the remaining bits read zero:
  - control (offset 0x00) keeps bits 30 (active-low program), 27 (partial reconfiguration enable) and 26 (configuration port enable);
  - lock (offset 0x04) keeps bits 4:0;
  - miscellaneous control (offset 0x80) keeps bit 4 (loopback select).
  
  Each of these registers is mirrored on `ctrl_out`, `lock_out` and `misc_out` respectively.
- R5: The DMA source address (0x18), destination address (0x1C), source length (0x20) and destination length (0x24) registers are full 32-bit read/write registers. Each is mirrored on its own output port.
- R6: Interrupt status (offset 0x0C) has the implemented bits 0xF8F7F87F:
  - a pulse on `evt_set[b]` sets implemented bit b, and the bit holds until cleared;
  - an accepted write clears every bit written as 1;
  - a set and a clear of the same bit in one cycle leave the bit set;
  - bits outside the implemented set never read as 1.
- R7: Mask (offset 0x10) has the same implemented bits as interrupt status. `irq_out` goes high one clock after some status bit is 1 while its mask bit is 0, and goes low one clock after no such bit remains. Writing 0xFFFFFFFF masks every source.
- R8: Status (offset 0x14) is read-only. Bit 31 shows `dma_queue_full` and bit 4 shows `init_level` in the same cycle, other bits read zero, and writes to it have no effect.
- R9: Offsets that are not mapped read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_set | input | 32 | One-cycle event pulses, one per interrupt status bit |
| dma_queue_full | input | 1 | DMA command queue full level |
| init_level | input | 1 | Configuration INIT level |
| irq_out | output | 1 | Registered interrupt request |
| ctrl_out | output | 32 | Control register contents |
| lock_out | output | 32 | Lock register contents |
| misc_out | output | 32 | Miscellaneous control contents |
| dma_src_addr | output | 32 | DMA source address |
| dma_dst_addr | output | 32 | DMA destination address |
| dma_src_len | output | 32 | DMA source length |
| dma_dst_len | output | 32 | DMA destination length |

## Verification
The hardest case to reach is a status bit being set by an event and cleared by software in the same clock. The bench drives an `evt_set` pulse and a write-one-to-clear on the same falling edge, so both land on one rising edge. It does this once with the same bit and once with different bits. A second awkward area is the locked state, where effects must be absent rather than present. The bench writes all ones to every one of the 64 word offsets and tries to clear pending status while locked, then reads the whole map back. It also offers wrong keys before and after the right one.

// File: rtl/cfgctl_pkg.sv
// Shared constants for the configuration controller register bank.
// Assumes byte offsets on a 32-bit word bus; offsets fit in 8 bits.
package cfgctl_pkg;

    localparam int DW        = 32;
    localparam int NUM_STORE = 8;

    localparam logic [DW-1:0] UNLOCK_KEY = 32'h757B_DF0D;
    localparam logic [DW-1:0] IRQ_IMPL   = 32'hF8F7_F87F;

    localparam int OFF_ISR    = 8'h0C;
    localparam int OFF_STATUS = 8'h14;
    localparam int OFF_UNLOCK = 8'h34;

    localparam int STS_QFULL_BIT = 31;
    localparam int STS_INIT_BIT  = 4;

    // Storage registers: index 0 ctrl, 1 lock, 2 mask, 3 src addr,
    // 4 dst addr, 5 src len, 6 dst len, 7 misc control.
    localparam int STORE_OFF [NUM_STORE] = '{
        8'h00, 8'h04, 8'h10, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h80
    };
    localparam logic [DW-1:0] STORE_IMPL [NUM_STORE] = '{
        32'h4C00_0000, 32'h0000_001F, IRQ_IMPL, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0010
    };
    localparam logic [DW-1:0] STORE_RST [NUM_STORE] = '{
        32'h0, 32'h0, IRQ_IMPL, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0
    };

    localparam int IDX_CTRL = 0;
    localparam int IDX_LOCK = 1;
    localparam int IDX_MASK = 2;
    localparam int IDX_SRCA = 3;
    localparam int IDX_DSTA = 4;
    localparam int IDX_SRCL = 5;
    localparam int IDX_DSTL = 6;
    localparam int IDX_MISC = 7;

endpackage

// File: rtl/cfgctl_keygate.sv
// Unlock gate: opens once the key is written to the unlock register
// and stays open until reset. Assumes wr_unlock is a qualified write strobe.
module cfgctl_keygate (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_unlock,
    input  logic [31:0] wdata,
    output logic        unlocked
);
    import cfgctl_pkg::*;

    // Latch the open state on a matching key write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlocked <= 1'b0;
        else if (wr_unlock && wdata == UNLOCK_KEY)
            unlocked <= 1'b1;
    end
endmodule

// File: rtl/cfgctl_store.sv
// Plain storage register with a per-bit implemented mask.
// Assumes we is already qualified by decode and the unlock gate.
module cfgctl_store #(
    parameter int              W    = 32,
    parameter logic [W-1:0]    IMPL = '1,
    parameter logic [W-1:0]    RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Capture write data, keeping only implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST & IMPL;
        else if (we)
            q <= wdata & IMPL;
    end
endmodule

// File: rtl/cfgctl_irq.sv
// Sticky interrupt status with write-one-to-clear and a registered,
// masked interrupt line. Set events win over a same-cycle clear.
module cfgctl_irq #(
    parameter int           W    = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    input  logic [W-1:0] evt_set,
    input  logic [W-1:0] mask,
    output logic [W-1:0] status,
    output logic         irq
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (IMPL[b]) begin : g_impl
            // Sticky bit: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    status[b] <= 1'b0;
                else if (evt_set[b])
                    status[b] <= 1'b1;
                else if (clr_we && clr_data[b])
                    status[b] <= 1'b0;
            end
        end else begin : g_tie
            assign status[b] = 1'b0;
        end
    end

    // Register the OR of unmasked pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |(status & ~mask);
    end
endmodule

// File: rtl/cfgctl_regbank.sv
// Register bank top: decodes the bus, gates writes behind the unlock
// key, holds storage registers and interrupt status, muxes reads.
// Assumes reads are combinational and writes complete in one cycle.
module cfgctl_regbank #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       evt_set,
    input  logic              dma_queue_full,
    input  logic              init_level,
    output logic              irq_out,
    output logic [31:0]       ctrl_out,
    output logic [31:0]       lock_out,
    output logic [31:0]       misc_out,
    output logic [31:0]       dma_src_addr,
    output logic [31:0]       dma_dst_addr,
    output logic [31:0]       dma_src_len,
    output logic [31:0]       dma_dst_len
);
    import cfgctl_pkg::*;

    logic                 unlocked;
    logic                 wr_any;
    logic                 wr_acc;
    logic                 hit_isr;
    logic                 hit_status;
    logic                 hit_unlock;
    logic [NUM_STORE-1:0] hit_store;
    logic [DW-1:0]        store_q [NUM_STORE];
    logic [DW-1:0]        isr_q;
    logic [DW-1:0]        mask_q;
    logic [DW-1:0]        status_word;

    assign wr_any     = bus_valid && bus_write;
    assign wr_acc     = wr_any && unlocked;
    assign hit_isr    = (bus_addr == ADDR_W'(OFF_ISR));
    assign hit_status = (bus_addr == ADDR_W'(OFF_STATUS));
    assign hit_unlock = (bus_addr == ADDR_W'(OFF_UNLOCK));

    cfgctl_keygate u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_unlock (wr_any && hit_unlock),
        .wdata     (bus_wdata),
        .unlocked  (unlocked)
    );

    for (genvar i = 0; i < NUM_STORE; i++) begin : g_store
        assign hit_store[i] = (bus_addr == ADDR_W'(STORE_OFF[i]));
        cfgctl_store #(
            .W    (DW),
            .IMPL (STORE_IMPL[i]),
            .RST  (STORE_RST[i])
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_acc && hit_store[i]),
            .wdata (bus_wdata),
            .q     (store_q[i])
        );
    end

    assign mask_q = store_q[IDX_MASK];

    cfgctl_irq #(
        .W    (DW),
        .IMPL (IRQ_IMPL)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (wr_acc && hit_isr),
        .clr_data (bus_wdata),
        .evt_set  (evt_set),
        .mask     (mask_q),
        .status   (isr_q),
        .irq      (irq_out)
    );

    // Build the read-only status word from neighbour levels.
    always_comb begin
        status_word                = '0;
        status_word[STS_QFULL_BIT] = dma_queue_full;
        status_word[STS_INIT_BIT]  = init_level;
    end

    // Read mux: unmapped offsets and the unlock register return zero.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_STORE; i++)
            if (hit_store[i])
                bus_rdata = store_q[i];
        if (hit_isr)
            bus_rdata = isr_q;
        if (hit_status)
            bus_rdata = status_word;
    end

    assign ctrl_out     = store_q[IDX_CTRL];
    assign lock_out     = store_q[IDX_LOCK];
    assign misc_out     = store_q[IDX_MISC];
    assign dma_src_addr = store_q[IDX_SRCA];
    assign dma_dst_addr = store_q[IDX_DSTA];
    assign dma_src_len  = store_q[IDX_SRCL];
    assign dma_dst_len  = store_q[IDX_DSTL];
endmodule

// File: rtl/cfgctl_regbank_chk.sv
// Property checker for the register bank, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module cfgctl_regbank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       evt_set,
    input logic              unlocked,
    input logic [31:0]       isr_q,
    input logic [31:0]       mask_q,
    input logic              irq_out,
    input logic [31:0]       ctrl_out
);
    import cfgctl_pkg::*;

    logic key_wr;
    assign key_wr = bus_valid && bus_write && bus_addr == ADDR_W'(OFF_UNLOCK)
                    && bus_wdata == UNLOCK_KEY;

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> unlocked); // R2
    AST_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked); // R2
    AST_WRONG_KEY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && !key_wr) |=> !unlocked); // R2
    AST_LOCKED_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !unlocked && bus_addr == '0) |=> $stable(ctrl_out)); // R3
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((isr_q & $past(evt_set & IRQ_IMPL)) == $past(evt_set & IRQ_IMPL))); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && unlocked && bus_addr == ADDR_W'(OFF_ISR))
        |=> ((isr_q & $past(bus_wdata & ~evt_set)) == 0)); // R6
    AST_ISR_IMPL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_q & ~IRQ_IMPL) == 0); // R6
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(isr_q & ~mask_q)))); // R7
endmodule

bind cfgctl_regbank cfgctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_set   (evt_set),
    .unlocked  (unlocked),
    .isr_q     (isr_q),
    .mask_q    (mask_q),
    .irq_out   (irq_out),
    .ctrl_out  (ctrl_out)
);

// File: tb/cfgctl_regbank_test.sv
`timescale 1ns/1ps
// Bench: sweeps every word offset and every interrupt bit against an
// arithmetic model built from the requirements.
module cfgctl_regbank_test;
    localparam logic [31:0] KEY   = 32'h757B_DF0D;
    localparam logic [31:0] IMPLI = 32'hF8F7_F87F;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_valid = 0, bus_write = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata, evt_set = 0;
    logic        dma_queue_full = 0, init_level = 0, irq_out;
    logic [31:0] ctrl_out, lock_out, misc_out;
    logic [31:0] dma_src_addr, dma_dst_addr, dma_src_len, dma_dst_len;

    int checks = 0, fails = 0;
    bit done = 0;

    logic        m_unl;
    logic [31:0] m_ctrl, m_lock, m_mask, m_isr, m_sa, m_da, m_sl, m_dl, m_misc;

    always #5 clk = ~clk;

    cfgctl_regbank uut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_unl = 0; m_ctrl = 0; m_lock = 0; m_mask = IMPLI; m_isr = 0;
        m_sa = 0; m_da = 0; m_sl = 0; m_dl = 0; m_misc = 0;
    endtask

    function automatic logic [31:0] model_rd(logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h04: return m_lock;
            8'h0C: return m_isr;
            8'h10: return m_mask;
            8'h14: return {dma_queue_full, 26'b0, init_level, 4'b0};
            8'h18: return m_sa;
            8'h1C: return m_da;
            8'h20: return m_sl;
            8'h24: return m_dl;
            8'h80: return m_misc;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_wr(logic [7:0] a, logic [31:0] d);
        if (a == 8'h34) begin
            if (d == KEY) m_unl = 1;
        end else if (m_unl) begin
            case (a)
                8'h00: m_ctrl = d & 32'h4C00_0000;
                8'h04: m_lock = d & 32'h1F;
                8'h0C: m_isr  = m_isr & ~d;
                8'h10: m_mask = d & IMPLI;
                8'h18: m_sa = d;
                8'h1C: m_da = d;
                8'h20: m_sl = d;
                8'h24: m_dl = d;
                8'h80: m_misc = d & 32'h10;
                default: ;
            endcase
        end
    endtask

    // Drive a write on the low phase, hold across one rising edge.
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        model_wr(a, d);
    endtask

    task automatic rd(string tag, logic [7:0] a);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, model_rd(a));
        bus_valid = 0;
    endtask

    task automatic pulse(logic [31:0] v);
        evt_set = v;
        @(negedge clk);
        evt_set = 0;
        m_isr = m_isr | (v & IMPLI);
    endtask

    task automatic sweep(string tag);
        for (int o = 0; o < 256; o += 4) rd(tag, 8'(o));
    endtask

    task automatic chk_outs(string tag);
        chk({tag, " ctrl_out"}, ctrl_out, m_ctrl);
        chk({tag, " lock_out"}, lock_out, m_lock);
        chk({tag, " misc_out"}, misc_out, m_misc);
        chk({tag, " src_addr"}, dma_src_addr, m_sa);
        chk({tag, " dst_addr"}, dma_dst_addr, m_da);
        chk({tag, " src_len"}, dma_src_len, m_sl);
        chk({tag, " dst_len"}, dma_dst_len, m_dl);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state across the whole map and outputs
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
        sweep("R1 reset map");
        chk_outs("R1");

        // R3: locked writes everywhere, and locked clear attempt
        pulse(32'hFFFF_FFFF);
        for (int o = 0; o < 256; o += 4)
            if (o != 8'h34) wr(8'(o), 32'hFFFF_FFFF);
        sweep("R3 locked map");
        chk_outs("R3");

        // R2: wrong keys keep it locked
        wr(8'h34, 32'h0);
        wr(8'h34, KEY ^ 32'h1);
        wr(8'h00, 32'hFFFF_FFFF);
        rd("R2 wrong key ctrl", 8'h00);
        wr(8'h34, KEY);
        rd("R2 unlock reads zero", 8'h34);
        wr(8'h00, 32'hFFFF_FFFF);
        rd("R2 opened ctrl", 8'h00);
        wr(8'h34, 32'h1234_5678);
        wr(8'h00, 32'h0400_0000);
        rd("R2 stays open", 8'h00);

        // R4 R5 R9: write every offset with two patterns, sweep back
        for (int p = 0; p < 2; p++) begin
            for (int o = 0; o < 256; o += 4)
                if (o != 8'h34 && o != 8'h0C)
                    wr(8'(o), (p == 0) ? 32'hFFFF_FFFF : (32'hA5C3_96F0 ^ (o * 32'h0101_0101)));
            sweep("R4 R5 R9 map");
            chk_outs("R4 R5");
        end

        // R8: status levels and write immunity
        for (int s = 0; s < 4; s++) begin
            dma_queue_full = s[1]; init_level = s[0];
            @(negedge clk);
            rd("R8 status", 8'h14);
            wr(8'h14, 32'h0);
            rd("R8 status after write", 8'h14);
        end

        // R6 R7: per-bit set, irq, clear
        wr(8'h10, 32'h0);
        wr(8'h0C, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R7 irq idle", {31'b0, irq_out}, 32'h0);
        for (int b = 0; b < 32; b++) begin
            pulse(32'h1 << b);
            rd("R6 sticky set", 8'h0C);
            @(negedge clk);
            chk("R7 irq unmasked", {31'b0, irq_out}, {31'b0, IMPLI[b]});
            wr(8'h0C, 32'h1 << b);
            rd("R6 w1c", 8'h0C);
            @(negedge clk);
            chk("R7 irq cleared", {31'b0, irq_out}, 32'h0);
        end
        for (int b = 0; b < 32; b++) begin
            wr(8'h10, 32'h1 << b);
            pulse(32'h1 << b);
            @(negedge clk);
            chk("R7 irq masked", {31'b0, irq_out}, 32'h0);
            wr(8'h0C, 32'hFFFF_FFFF);
        end
        wr(8'h10, 32'hFFFF_FFFF);
        rd("R7 mask all", 8'h10);
        pulse(32'hFFFF_FFFF);
        @(negedge clk);
        chk("R7 irq all masked", {31'b0, irq_out}, 32'h0);
        wr(8'h10, 32'h0000_2000);
        @(negedge clk);
        chk("R7 irq after unmask", {31'b0, irq_out}, 32'h1);

        // R6: set wins over same-cycle clear; other bits still clear
        wr(8'h0C, 32'hFFFF_FFFF);
        pulse(32'h0000_3000);
        evt_set = 32'h0000_2000;
        wr(8'h0C, 32'h0000_3000);
        evt_set = 0;
        m_isr = 32'h0000_2000;
        rd("R6 set beats clear", 8'h0C);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule